// File: doc/BRIEF.md
# Interrupt Event Latch and Poll Responder

This block records the state of a bank of general-purpose input pins at the moment an external interrupt request line goes high. It keeps that snapshot until a host-side interrupt pipe polls for it. Each poll strobe gets exactly one response one cycle later. The response is marked as data when a snapshot is waiting and as NAK when nothing is waiting. A pending flag shows that an unread snapshot is held.

The request line is brought through a two-flop synchronizer before use. The pin bank is not synchronized. It must be stable from the cycle the request rises until the capture edge. After a capture the block is disarmed. It arms again only when two conditions hold together: the snapshot has been delivered, and the synchronized request line has returned low. A request held high for a long time therefore produces one report.

Top module: `irq_snap_responder`

## Requirements
- R1: After reset, `pending_o`, `resp_vld_o`, `resp_nak_o` and `resp_data_o` are all 0, and the block is armed: the first request after reset is captured.
- R2: When `irq_req_i` is sampled high on a rising edge while the block is armed, `pending_o` goes to 1 after the third rising edge counted from that one. That is two synchronizer flops plus the capture flop.
- R3: The snapshot holds the `gpio_i` value present at the capture edge. Later changes on `gpio_i` do not alter the reported data.
- R4: A poll strobe seen while `pending_o` is 1 gives, on the next cycle, `resp_vld_o`=1, `resp_nak_o`=0 and `resp_data_o` equal to the snapshot. `pending_o` goes to 0 on the same edge.
- R5: A poll strobe seen while `pending_o` is 0 gives, on the next cycle, `resp_vld_o`=1, `resp_nak_o`=1 and `resp_data_o`=0.
- R6: `resp_vld_o` is 1 in exactly the cycle after each cycle in which `poll_i` is 1, and 0 otherwise. Back-to-back polls give back-to-back responses.
- R7: While the request line stays high after its snapshot was delivered, no new capture takes place. One long request yields one report.
- R8: Once the snapshot has been delivered and the synchronized request line is low, the block arms again. The next request captures the pin value present at its own capture edge.
- R9: If a capture and a poll fall on the same edge, the poll is answered with NAK. The new snapshot stays pending and is returned by the next poll.
- R10: While a snapshot is pending, further request pulses do not overwrite it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_req_i | input | 1 | Interrupt request line, asynchronous |
| gpio_i | input | GPIO_W | General-purpose pin states to be captured |
| poll_i | input | 1 | One-cycle poll strobe from the interrupt pipe |
| resp_vld_o | output | 1 | One-cycle response strobe, the cycle after a poll |
| resp_nak_o | output | 1 | 1 = NAK, 0 = data, valid with `resp_vld_o` |
| resp_data_o | output | GPIO_W | Delivered snapshot on a data response, 0 on NAK |
| pending_o | output | 1 | An unread snapshot is held |

## Verification
The bench sweeps every 8-bit pin pattern through a full cycle of request, pin change, poll and second poll. A design that sampled the pins at poll time, or that did not arm again after delivery, would return the changed or stale value. A held-high request is polled twice, and a design that armed again on the pending flag alone would report twice. A poll is placed on the exact capture edge, where a design that forwarded the fresh capture or dropped it would give data instead of NAK or lose the report. Request pulses during a pending snapshot check that the first value survives.

// File: rtl/irq_snap_pkg.sv
`timescale 1ns/1ps
package irq_snap_pkg;
  // Response kind carried on the nak bit
  typedef enum logic {
    RESP_DATA = 1'b0,
    RESP_NAK  = 1'b1
  } resp_kind_e;

  localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/irq_snap_rst_sync.sv
`timescale 1ns/1ps
module irq_snap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_snap_bit_sync.sv
`timescale 1ns/1ps
module irq_snap_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_snap_capture.sv
`timescale 1ns/1ps
module irq_snap_capture #(
  parameter int GPIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_s_i,
  input  logic [GPIO_W-1:0] gpio_i,
  input  logic              deliver_i,
  output logic              pending_o,
  output logic [GPIO_W-1:0] snap_o
);
  logic              armed_q, armed_d;
  logic              pending_q, pending_d;
  logic [GPIO_W-1:0] snap_q;
  logic              capture;

  // A capture fires only while armed; armed already implies nothing pending
  assign capture = armed_q & irq_s_i;

  always_comb begin
    pending_d = pending_q;
    if (deliver_i) pending_d = 1'b0;
    if (capture)   pending_d = 1'b1;

    armed_d = armed_q;
    if (capture)                      armed_d = 1'b0;
    else if (!pending_q && !irq_s_i)  armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b1;
      pending_q <= 1'b0;
    end else begin
      armed_q   <= armed_d;
      pending_q <= pending_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (capture) snap_q <= gpio_i;
  end

  assign pending_o = pending_q;
  assign snap_o    = snap_q;
endmodule

// File: rtl/irq_snap_resp.sv
`timescale 1ns/1ps
module irq_snap_resp
  import irq_snap_pkg::*;
#(
  parameter int GPIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_i,
  input  logic              pending_i,
  input  logic [GPIO_W-1:0] snap_i,
  output logic              deliver_o,
  output logic              vld_o,
  output logic              nak_o,
  output logic [GPIO_W-1:0] data_o
);
  logic              vld_q, vld_d;
  resp_kind_e        kind_q, kind_d;
  logic [GPIO_W-1:0] data_q, data_d;

  assign deliver_o = poll_i & pending_i;

  always_comb begin
    vld_d  = poll_i;
    kind_d = kind_q;
    data_d = data_q;
    if (poll_i) begin
      kind_d = pending_i ? RESP_DATA : RESP_NAK;
      data_d = pending_i ? snap_i : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      kind_q <= RESP_DATA;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      kind_q <= kind_d;
      data_q <= data_d;
    end
  end

  assign vld_o  = vld_q;
  assign nak_o  = (kind_q == RESP_NAK);
  assign data_o = data_q;
endmodule

// File: rtl/irq_snap_responder.sv
`timescale 1ns/1ps
module irq_snap_responder
  import irq_snap_pkg::*;
#(
  parameter int GPIO_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req_i,
  input  logic [GPIO_W-1:0] gpio_i,
  input  logic              poll_i,
  output logic              resp_vld_o,
  output logic              resp_nak_o,
  output logic [GPIO_W-1:0] resp_data_o,
  output logic              pending_o
);
  localparam int STAGES = (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic              rst_q_n;
  logic              irq_s;
  logic              deliver;
  logic              pending;
  logic [GPIO_W-1:0] snap;

  irq_snap_rst_sync #(.STAGES(STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_q_n)
  );

  irq_snap_bit_sync #(.STAGES(STAGES)) u_irq_sync (
    .clk(clk), .rst_n(rst_q_n), .d_i(irq_req_i), .q_o(irq_s)
  );

  irq_snap_capture #(.GPIO_W(GPIO_W)) u_cap (
    .clk(clk), .rst_n(rst_q_n), .irq_s_i(irq_s), .gpio_i(gpio_i),
    .deliver_i(deliver), .pending_o(pending), .snap_o(snap)
  );

  irq_snap_resp #(.GPIO_W(GPIO_W)) u_resp (
    .clk(clk), .rst_n(rst_q_n), .poll_i(poll_i), .pending_i(pending),
    .snap_i(snap), .deliver_o(deliver), .vld_o(resp_vld_o),
    .nak_o(resp_nak_o), .data_o(resp_data_o)
  );

  assign pending_o = pending;
endmodule

// File: rtl/irq_snap_checks.sv
`timescale 1ns/1ps
module irq_snap_checks #(
  parameter int GPIO_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_s,
  input logic              poll_i,
  input logic              pending,
  input logic              resp_vld,
  input logic              resp_nak,
  input logic [GPIO_W-1:0] resp_data,
  input logic [GPIO_W-1:0] snap
);
  // R4
  data_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && poll_i) |=> (resp_vld && !resp_nak && !pending && resp_data == $past(snap)));

  // R5
  nak_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && poll_i) |=> (resp_vld && resp_nak && resp_data == '0));

  // R6
  one_resp_per_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_i |=> !resp_vld);

  // R2
  capture_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(irq_s));

  // R10
  snap_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !poll_i) |=> (pending && $stable(snap)));
endmodule

bind irq_snap_responder irq_snap_checks #(.GPIO_W(GPIO_W)) i_chk (
  .clk(clk), .rst_n(rst_q_n), .irq_s(irq_s), .poll_i(poll_i),
  .pending(pending_o), .resp_vld(resp_vld_o), .resp_nak(resp_nak_o),
  .resp_data(resp_data_o), .snap(snap)
);

// File: tb/test_irq_snap_responder.sv
`timescale 1ns/1ps
module test_irq_snap_responder;
  localparam int  CLK_PERIOD = 10;
  localparam int  W          = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         irq;
  logic [W-1:0] gpio;
  logic         poll;
  logic         vld, nak, pend;
  logic [W-1:0] data;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_snap_responder #(.GPIO_W(W), .SYNC_STAGES(2)) i_irq_snap_responder (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq), .gpio_i(gpio), .poll_i(poll),
    .resp_vld_o(vld), .resp_nak_o(nak), .resp_data_o(data), .pending_o(pend)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Raise the request with value v on the pins; pending must appear after the third edge
  task automatic raise_irq(input logic [W-1:0] v, input string req);
    gpio = v;
    irq  = 1'b1;
    tick(); chk({req, " R2 pending edge1"}, pend, 0);
    tick(); chk({req, " R2 pending edge2"}, pend, 0);
    tick(); chk({req, " R2 pending edge3"}, pend, 1);
  endtask

  task automatic poll_expect(input int exp_nak, input int exp_data, input string req);
    poll = 1'b1;
    tick();
    poll = 1'b0;
    chk({req, " vld"},  vld,  1);
    chk({req, " nak"},  nak,  exp_nak);
    chk({req, " data"}, data, exp_data);
    tick();
    chk({req, " R6 vld drop"}, vld, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq = 1'b0; gpio = '0; poll = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    chk("R1 pending", pend, 0);
    chk("R1 vld", vld, 0);
    chk("R1 nak", nak, 0);
    chk("R1 data", data, 0);

    // R5 poll with nothing pending
    poll_expect(1, 0, "R5 idle poll");

    // R3 R4 R8 sweep of every pin pattern
    for (int v = 0; v < (1 << W); v++) begin
      raise_irq(v[W-1:0], "R8 sweep");
      gpio = ~v[W-1:0];
      irq  = 1'b0;
      poll_expect(0, v, "R3 R4 sweep data");
      chk("R4 pending cleared", pend, 0);
      poll_expect(1, 0, "R5 sweep second poll");
    end

    // R7 long request yields one report
    raise_irq(8'h5A, "R7");
    poll_expect(0, 8'h5A, "R7 first report");
    repeat (5) tick();
    chk("R7 no recapture", pend, 0);
    poll_expect(1, 0, "R7 second poll");
    irq = 1'b0;
    repeat (3) tick();
    raise_irq(8'hA5, "R8 rearm");
    irq = 1'b0;
    poll_expect(0, 8'hA5, "R8 rearm data");

    // R10 pulses while pending do not overwrite
    raise_irq(8'h11, "R10");
    gpio = 8'h22;
    irq  = 1'b0;
    repeat (3) tick();
    irq  = 1'b1;
    repeat (4) tick();
    irq  = 1'b0;
    chk("R10 still pending", pend, 1);
    poll_expect(0, 8'h11, "R10 first value kept");
    repeat (3) tick();
    raise_irq(8'h33, "R10 after");
    irq = 1'b0;
    poll_expect(0, 8'h33, "R10 later capture");

    // R9 capture and poll on the same edge
    repeat (3) tick();
    gpio = 8'h77;
    irq  = 1'b1;
    tick();
    tick();
    poll = 1'b1;
    tick();
    poll = 1'b0;
    chk("R9 vld", vld, 1);
    chk("R9 nak", nak, 1);
    chk("R9 pending kept", pend, 1);
    irq = 1'b0;
    tick();
    chk("R9 vld drop", vld, 0);
    gpio = 8'h00;
    poll_expect(0, 8'h77, "R9 later poll");

    // R6 back-to-back polls
    repeat (3) tick();
    raise_irq(8'hC3, "R6");
    irq  = 1'b0;
    poll = 1'b1;
    tick();
    chk("R6 first vld", vld, 1);
    chk("R6 first nak", nak, 0);
    chk("R6 first data", data, 8'hC3);
    tick();
    poll = 1'b0;
    chk("R6 second vld", vld, 1);
    chk("R6 second nak", nak, 1);
    tick();
    chk("R6 idle vld", vld, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule